// File: doc/BRIEF.md
# Line-Rate Mode Selection Register Block

This block sits in one Ethernet port's management space and records which line mode software has requested. The choices are automatic 1G/10G speed detection, forced 10G, forced 1G in 1000BASE-X, and SGMII at 10M, 100M or 1G, or with SGMII auto-negotiation. Software selects a mode by writing fixed codes to two control registers. One holds the sequencer setting (auto, 1G or 10G). The other holds the SGMII setting, which only takes effect while the port is forced to 1G.

Whenever the effective mode changes, the block drives the new mode code and raises a reconfiguration request toward the transceiver reconfiguration logic. The request stays high until that logic acknowledges it. While a request is outstanding, a link-ready status register reads 0. Register reads return their data one cycle after the read strobe.

Top module: `lrm_line_mode_ctl`

## Requirements
- R1: After reset, mode_code is 0 (auto detection, port running at 10G) and reconf_req is 0. The sequencer register reads 0x01, the SGMII register reads 0x00 and link-ready reads 1.
- R2: A write to word offset 0xB0 (sequencer control) selects a mode. 0x01 gives auto detection (mode code 0), 0x11 gives forced 1G 1000BASE-X (code 2) and 0x41 gives forced 10G (code 1).
- R3: While the sequencer holds 0x11, a write to word offset 0xA4 (SGMII control) selects SGMII mode. 0x01 gives 10M (code 3), 0x05 gives 100M (code 4), 0x09 gives 1G (code 5) and 0x03 gives auto-negotiation (code 6).
- R4: An SGMII write while the sequencer does not hold 0x11 is stored and reads back, but mode_code does not change. A following write of 0x11 to the sequencer applies the stored SGMII setting.
- R5: Writing 0x41 or 0x01 to the sequencer clears the stored SGMII setting, so the SGMII register then reads 0x00.
- R6: A write of any value outside the listed codes, to either control register, is ignored: mode_code and both read values stay unchanged. Any write with wr_en low also leaves mode_code unchanged.
- R7: When the effective mode changes, mode_code takes the new code and reconf_req is 1 on the clock edge that accepts the write. A write that leaves the effective mode unchanged does not raise reconf_req.
- R8: reconf_req stays 1 until reconf_ack is sampled high, and it clears on that edge. A mode change on the same edge as the acknowledge keeps reconf_req at 1.
- R9: A read of word offset 0xB1 (link-ready) returns bit 0 equal to the inverse of reconf_req at the read edge. All other bits read 0. Writes to this offset have no effect.
- R10: rd_valid and rdata appear on the edge after rd_en. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| rd_valid | output | 1 | rdata is valid |
| mode_code | output | 3 | Effective line mode code |
| reconf_req | output | 1 | Reconfiguration request |
| reconf_ack | input | 1 | Reconfiguration acknowledge |

## Verification
The bench builds the block with its default parameters: 10-bit word offsets and 32-bit data, with the three registers at 0xB0, 0xA4 and 0xB1. These defaults cover every listed code and let the bench place junk values in the upper data bits. They also allow an unmapped offset at 0 and a write aimed at the read-only link-ready word. With the default widths the bench can reach the order-dependent cases. These include SGMII writes that arrive before the 1G force, a fall back to 10G that wipes the stored setting, and a mode change that coincides with an acknowledge.

// File: rtl/lrm_pkg.sv
package lrm_pkg;
  typedef enum logic [2:0] {
    LM_AUTO    = 3'd0,
    LM_10G     = 3'd1,
    LM_1G_BX   = 3'd2,
    LM_SG_10M  = 3'd3,
    LM_SG_100M = 3'd4,
    LM_SG_1G   = 3'd5,
    LM_SG_AN   = 3'd6
  } line_mode_e;

  localparam logic [7:0] SEQ_AUTO = 8'h01;
  localparam logic [7:0] SEQ_F1G  = 8'h11;
  localparam logic [7:0] SEQ_F10G = 8'h41;

  localparam logic [7:0] SGC_10M  = 8'h01;
  localparam logic [7:0] SGC_AN   = 8'h03;
  localparam logic [7:0] SGC_100M = 8'h05;
  localparam logic [7:0] SGC_1G   = 8'h09;

  function automatic line_mode_e mode_of(input logic [7:0] seq, input logic [7:0] sgc);
    line_mode_e m;
    m = LM_AUTO;
    if (seq == SEQ_F10G) m = LM_10G;
    else if (seq == SEQ_F1G) begin
      case (sgc)
        SGC_10M:  m = LM_SG_10M;
        SGC_100M: m = LM_SG_100M;
        SGC_1G:   m = LM_SG_1G;
        SGC_AN:   m = LM_SG_AN;
        default:  m = LM_1G_BX;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/lrm_wr_decode.sv
module lrm_wr_decode #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SEQ_OFS = 'h0B0,
  parameter logic [ADDR_W-1:0] SGC_OFS = 'h0A4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              seq_ok,
  output logic              sgc_ok,
  output logic [7:0]        code
);
  import lrm_pkg::*;

  logic hi_clear;

  generate
    if (DATA_W > 8) begin : g_hi
      assign hi_clear = (wdata[DATA_W-1:8] == '0);
    end else begin : g_nohi
      assign hi_clear = 1'b1;
    end
  endgenerate

  assign code = wdata[7:0];

  always_comb begin
    seq_ok = 1'b0;
    sgc_ok = 1'b0;
    if (wr_en && hi_clear) begin
      if (addr == SEQ_OFS)
        seq_ok = (code == SEQ_AUTO) || (code == SEQ_F1G) || (code == SEQ_F10G);
      if (addr == SGC_OFS)
        sgc_ok = (code == SGC_10M) || (code == SGC_AN) ||
                 (code == SGC_100M) || (code == SGC_1G);
    end
  end
endmodule

// File: rtl/lrm_mode_state.sv
module lrm_mode_state (
  input  logic                clk,
  input  logic                rst,
  input  logic                seq_ok,
  input  logic                sgc_ok,
  input  logic [7:0]          code,
  output logic [7:0]          seq_q,
  output logic [7:0]          sgc_q,
  output lrm_pkg::line_mode_e eff_next
);
  import lrm_pkg::*;

  logic [7:0] seq_d, sgc_d;

  always_comb begin
    seq_d = seq_q;
    sgc_d = sgc_q;
    if (seq_ok) begin
      seq_d = code;
      if (code != SEQ_F1G) sgc_d = 8'h00;
    end else if (sgc_ok) begin
      sgc_d = code;
    end
    eff_next = mode_of(seq_d, sgc_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= SEQ_AUTO;
      sgc_q <= 8'h00;
    end else begin
      seq_q <= seq_d;
      sgc_q <= sgc_d;
    end
  end
endmodule

// File: rtl/lrm_reconf_hs.sv
module lrm_reconf_hs (
  input  logic                clk,
  input  logic                rst,
  input  lrm_pkg::line_mode_e eff_next,
  input  logic                ack,
  output lrm_pkg::line_mode_e mode_q,
  output logic                req_q
);
  import lrm_pkg::*;

  logic changed;
  assign changed = (eff_next != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= LM_AUTO;
      req_q  <= 1'b0;
    end else begin
      mode_q <= eff_next;
      if (changed)  req_q <= 1'b1;
      else if (ack) req_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lrm_rd_port.sv
module lrm_rd_port #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SEQ_OFS  = 'h0B0,
  parameter logic [ADDR_W-1:0] SGC_OFS  = 'h0A4,
  parameter logic [ADDR_W-1:0] LINK_OFS = 'h0B1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        seq_q,
  input  logic [7:0]        sgc_q,
  input  logic              link_up,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  localparam int PADW = DATA_W - 8;

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == SEQ_OFS)       sel = {{PADW{1'b0}}, seq_q};
    else if (addr == SGC_OFS)  sel = {{PADW{1'b0}}, sgc_q};
    else if (addr == LINK_OFS) sel = {{(DATA_W-1){1'b0}}, link_up};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= sel;
    end
  end
endmodule

// File: rtl/lrm_line_mode_ctl.sv
module lrm_line_mode_ctl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SEQ_OFS  = 'h0B0,
  parameter logic [ADDR_W-1:0] SGC_OFS  = 'h0A4,
  parameter logic [ADDR_W-1:0] LINK_OFS = 'h0B1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic [2:0]        mode_code,
  output logic              reconf_req,
  input  logic              reconf_ack
);
  import lrm_pkg::*;

  logic       seq_ok, sgc_ok;
  logic [7:0] code, seq_q, sgc_q;
  line_mode_e eff_next, mode_q;

  lrm_wr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_OFS(SEQ_OFS), .SGC_OFS(SGC_OFS)
  ) u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .seq_ok(seq_ok), .sgc_ok(sgc_ok), .code(code)
  );

  lrm_mode_state u_state (
    .clk(clk), .rst(rst), .seq_ok(seq_ok), .sgc_ok(sgc_ok), .code(code),
    .seq_q(seq_q), .sgc_q(sgc_q), .eff_next(eff_next)
  );

  lrm_reconf_hs u_hs (
    .clk(clk), .rst(rst), .eff_next(eff_next), .ack(reconf_ack),
    .mode_q(mode_q), .req_q(reconf_req)
  );

  lrm_rd_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SEQ_OFS(SEQ_OFS), .SGC_OFS(SGC_OFS), .LINK_OFS(LINK_OFS)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .seq_q(seq_q), .sgc_q(sgc_q), .link_up(!reconf_req),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  assign mode_code = mode_q;
endmodule

// File: rtl/lrm_line_mode_ctl_chk.sv
module lrm_line_mode_ctl_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] LINK_OFS = 'h0B1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_valid,
  input logic [2:0]        mode_code,
  input logic              reconf_req,
  input logic              reconf_ack
);
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (mode_code == 3'd0 && !reconf_req));

  a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
    mode_code <= 3'd6);

  a_r6_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mode_code));

  a_r7_change_raises_req: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_code) |-> reconf_req);

  a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
    (reconf_req && !reconf_ack) |=> reconf_req);

  a_r9_link_ready_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == LINK_OFS) |=> (rd_valid && rdata[0] == !$past(reconf_req)));

  a_r10_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

bind lrm_line_mode_ctl lrm_line_mode_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINK_OFS(LINK_OFS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .rd_valid(rd_valid), .mode_code(mode_code),
  .reconf_req(reconf_req), .reconf_ack(reconf_ack)
);

// File: tb/tb_lrm_line_mode_ctl.sv
module tb_lrm_line_mode_ctl;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam logic [AW-1:0] SEQ  = 10'h0B0;
  localparam logic [AW-1:0] SGC  = 10'h0A4;
  localparam logic [AW-1:0] LINK = 10'h0B1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, reconf_ack = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_valid, reconf_req;
  logic [2:0] mode_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  lrm_line_mode_ctl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .mode_code(mode_code), .reconf_req(reconf_req), .reconf_ack(reconf_ack)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [2:0] m, input logic r);
    chk({tag, " mode"}, {29'b0, mode_code}, {29'b0, m});
    chk({tag, " req"}, {31'b0, reconf_req}, {31'b0, r});
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ack;
    @(negedge clk);
    reconf_ack = 1'b1;
    @(negedge clk);
    reconf_ack = 1'b0;
  endtask

  // Monitor: pops the expected read data as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10: unexpected rd_valid actual 1 expected 0");
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R1 reset", 3'd0, 1'b0);
    rd(SEQ, 32'h01, "R1 seq reset");
    rd(SGC, 32'h00, "R1 sgmii reset");
    rd(LINK, 32'h1, "R1 link reset");
    rd(10'h000, 32'h0, "R10 unmapped");

    wr(SEQ, 32'h11);
    chk_out("R2 force 1G", 3'd2, 1'b1);
    rd(LINK, 32'h0, "R9 link during req");
    wr(SGC, 32'h05);
    chk_out("R3 sgmii 100M", 3'd4, 1'b1);
    repeat (3) @(negedge clk);
    chk_out("R8 req held", 3'd4, 1'b1);
    ack();
    chk_out("R8 ack clears", 3'd4, 1'b0);
    rd(LINK, 32'h1, "R9 link after ack");

    wr(SGC, 32'h03);  chk_out("R3 sgmii AN", 3'd6, 1'b1);
    wr(SGC, 32'h09);  chk_out("R3 sgmii 1G", 3'd5, 1'b1);
    wr(SGC, 32'h01);  chk_out("R3 sgmii 10M", 3'd3, 1'b1);
    ack();

    wr(SGC, 32'h07);  chk_out("R6 bad sgmii", 3'd3, 1'b0);
    rd(SGC, 32'h01, "R6 sgmii readback");
    wr(SEQ, 32'h22);  chk_out("R6 bad seq", 3'd3, 1'b0);
    wr(SEQ, 32'h100); chk_out("R6 upper bits", 3'd3, 1'b0);
    rd(SEQ, 32'h11, "R6 seq readback");
    wr(LINK, 32'h0);  chk_out("R9 link write", 3'd3, 1'b0);
    rd(LINK, 32'h1, "R9 link unchanged");

    wr(SEQ, 32'h41);  chk_out("R2 force 10G", 3'd1, 1'b1);
    rd(SGC, 32'h00, "R5 sgmii cleared");
    ack();

    wr(SGC, 32'h05);  chk_out("R4 sgmii deferred", 3'd1, 1'b0);
    rd(SGC, 32'h05, "R4 sgmii stored");
    wr(SEQ, 32'h11);  chk_out("R4 sgmii applied", 3'd4, 1'b1);
    ack();
    wr(SEQ, 32'h11);  chk_out("R7 same mode", 3'd4, 1'b0);

    @(negedge clk);
    wr_en = 1'b1; addr = SEQ; wdata = 32'h01; reconf_ack = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; reconf_ack = 1'b0;
    chk_out("R8 change with ack", 3'd0, 1'b1);
    rd(SGC, 32'h00, "R5 auto clears sgmii");
    rd(SEQ, 32'h01, "R2 auto readback");
    ack();
    chk_out("R2 auto settled", 3'd0, 1'b0);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R10: pending reads actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule